// File: doc/BRIEF.md
# Voltmeter Auto-Range Sequencer

This block picks the input divider setting of a four-range dual-slope voltmeter. The four settings are 200 mV, 2 V, 20 V and 200 V. The range is held in a 4-bit up/down counter whose value is 0 for 200 mV, 1 for 2 V, 2 for 20 V and 3 for 200 V.

The block takes two raw status flags from the display logic. The over-range flag means the reading saturated. The under-range flag means the reading fell below 100 counts. The block filters both flags for glitches. After each conversion it moves the range by at most one step: up (less sensitive) on over-range, down (more sensitive) on under-range.

A step takes place only in the auto-zero window. It fires a fixed number of clock cycles after the rising edge of the auto-zero strobe, so the filtered flags have settled and no integration is disturbed. The counter value is decoded into one enable line per divider switch and into a decimal-point position for the display.

Top module: `dvm_range_sequencer`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `range_idx` is 3 (200 V), `sw_en` is 4'b1000 and `dp_pos` is 1.
- R2: When the filtered over-range flag is set and the filtered under-range flag is clear at a step, `range_idx` rises by exactly one.
- R3: When the filtered under-range flag is set and the filtered over-range flag is clear at a step, `range_idx` falls by exactly one.
- R4: Over-range has no effect at index 3, and under-range has no effect at index 0. The index stays within 0..3.
- R5: If both filtered flags are set, or neither is set, a step leaves `range_idx` unchanged.
- R6: Each rising edge of `az_strobe` allows at most one step, however long the strobe stays high. Without a rising edge the index never changes.
- R7: The edge that first samples `az_strobe` high is edge 0. A step updates `range_idx` on edge `STROBE_DELAY` after it (edge 2 by default), using the filtered flags present at that edge.
- R8: A raw flag is accepted only after it has held a new value for `FILT_LEN` (4) consecutive clock edges. A pulse of 3 cycles is ignored, and a flag accepted on its 4th edge still counts for 3 cycles after the raw flag drops.
- R9: `sw_en` is one-hot, with bit `range_idx` set.
- R10: `dp_pos` gives the number of digits right of the decimal point: index 0 -> 1, index 1 -> 3, index 2 -> 2, index 3 -> 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_raw | input | 1 | Raw over-range flag |
| udr_raw | input | 1 | Raw under-range flag |
| az_strobe | input | 1 | High during the auto-zero phase |
| range_idx | output | 4 | Range counter (0 = 200 mV ... 3 = 200 V) |
| sw_en | output | 4 | One-hot divider switch enables |
| dp_pos | output | 2 | Digits right of the decimal point |

## Verification
The index, switch enables and decimal point all change together. They change on the second edge after the edge that first samples the auto-zero strobe high. A flag level is accepted on the fourth edge at which it is held. The bench drives inputs on falling edges and samples on the falling edges that follow. The vector loop lets each flag settle for eight cycles before it strobes, and reads the outputs six cycles after the strobe starts. Directed checks then sample on each of the first three edges after a strobe rises, to pin down the exact step cycle. A further check sends a 3-cycle flag pulse to probe the filter length, and another sends a 4-cycle pulse followed at once by a strobe to probe how long an accepted flag holds.

// File: rtl/dvm_range_sequencer.sv
module dvm_range_sequencer #(
  parameter int CNT_W        = 4,
  parameter int NUM_RANGES   = 4,
  parameter int FILT_LEN     = 4,
  parameter int STROBE_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_raw,
  input  logic             udr_raw,
  input  logic             az_strobe,
  output logic [CNT_W-1:0] range_idx,
  output logic [NUM_RANGES-1:0] sw_en,
  output logic [1:0]       dp_pos
);
  localparam int FCW = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(NUM_RANGES - 1);
  localparam logic [FCW-1:0]   FILT_LAST = FCW'(FILT_LEN - 1);

  logic [1:0] raw_in, flt;
  assign raw_in = {udr_raw, ovr_raw};

  for (genvar f = 0; f < 2; f++) begin : g_filt
    logic [FCW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run    <= '0;
        flt[f] <= 1'b0;
      end else if (raw_in[f] == flt[f]) begin
        run <= '0;
      end else if (run == FILT_LAST) begin
        run    <= '0;
        flt[f] <= raw_in[f];
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  logic az_d, az_rise;
  logic [STROBE_DELAY-1:0] dly;
  assign az_rise = az_strobe & ~az_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) az_d <= 1'b0;
    else        az_d <= az_strobe;
  end

  if (STROBE_DELAY == 1) begin : g_dly1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly <= '0;
      else        dly <= az_rise;
    end
  end else begin : g_dlyn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly <= '0;
      else        dly <= {dly[STROBE_DELAY-2:0], az_rise};
    end
  end

  logic step, go_up, go_dn;
  assign step  = dly[STROBE_DELAY-1];
  assign go_up = step & flt[0] & ~flt[1] & (range_idx != TOP_IDX);
  assign go_dn = step & flt[1] & ~flt[0] & (range_idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     range_idx <= TOP_IDX;
    else if (go_up) range_idx <= range_idx + 1'b1;
    else if (go_dn) range_idx <= range_idx - 1'b1;
  end

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_sw
    assign sw_en[r] = (range_idx == CNT_W'(r));
  end

  assign dp_pos = (range_idx == '0) ? 2'd1 : 2'(3'd4 - 3'(range_idx));
endmodule

module dvm_range_sequencer_chk #(
  parameter int CNT_W        = 4,
  parameter int NUM_RANGES   = 4,
  parameter int STROBE_DELAY = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  az_strobe,
  input logic [CNT_W-1:0]      range_idx,
  input logic [NUM_RANGES-1:0] sw_en,
  input logic [1:0]            dp_pos
);
  logic       az_seen;
  logic [7:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      az_seen <= 1'b0;
      since   <= 8'hff;
    end else begin
      az_seen <= az_strobe;
      if (az_strobe && !az_seen) since <= 8'd0;
      else if (since != 8'hff)   since <= since + 8'd1;
    end
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> (range_idx == CNT_W'(NUM_RANGES - 1)) || !rst_n);

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (range_idx > $past(range_idx)) |-> (range_idx == $past(range_idx) + 1'b1));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (range_idx < $past(range_idx)) |-> (range_idx == $past(range_idx) - 1'b1));

  assert_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    range_idx <= CNT_W'(NUM_RANGES - 1));

  assert_step_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (range_idx != $past(range_idx)) |-> (since == 8'(STROBE_DELAY)));

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en) && sw_en[range_idx[1:0]]);

  assert_dp_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dp_pos != 2'd0);
endmodule

bind dvm_range_sequencer dvm_range_sequencer_chk #(
  .CNT_W(CNT_W), .NUM_RANGES(NUM_RANGES), .STROBE_DELAY(STROBE_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .az_strobe(az_strobe),
  .range_idx(range_idx), .sw_en(sw_en), .dp_pos(dp_pos)
);

// File: tb/tb_dvm_range_sequencer.sv
module tb_dvm_range_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovr_raw = 1'b0, udr_raw = 1'b0, az_strobe = 1'b0;
  logic [3:0] range_idx;
  logic [3:0] sw_en;
  logic [1:0] dp_pos;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dvm_range_sequencer dut (
    .clk(clk), .rst_n(rst_n), .ovr_raw(ovr_raw), .udr_raw(udr_raw),
    .az_strobe(az_strobe), .range_idx(range_idx), .sw_en(sw_en), .dp_pos(dp_pos)
  );

  // {ovr, udr, expected index}
  localparam logic [5:0] VEC [12] = '{
    {2'b01, 4'd2}, {2'b01, 4'd1}, {2'b01, 4'd0}, {2'b01, 4'd0},
    {2'b11, 4'd0}, {2'b00, 4'd0}, {2'b10, 4'd1}, {2'b10, 4'd2},
    {2'b10, 4'd3}, {2'b10, 4'd3}, {2'b00, 4'd3}, {2'b01, 4'd2}
  };

  function automatic logic [1:0] exp_dp(input int idx);
    case (idx)
      0: exp_dp = 2'd1;
      1: exp_dp = 2'd3;
      2: exp_dp = 2'd2;
      default: exp_dp = 2'd1;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int idx);
    check({req, " idx"}, int'(range_idx), idx);
    check("R9 sw_en", int'(sw_en), 1 << idx);
    check("R10 dp_pos", int'(dp_pos), int'(exp_dp(idx)));
  endtask

  task automatic strobe();
    az_strobe = 1'b1;
    repeat (3) @(negedge clk);
    az_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset", 3);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset", 3);

    // R2 R3 R4 R5 vectors
    foreach (VEC[i]) begin
      {ovr_raw, udr_raw} = VEC[i][5:4];
      repeat (8) @(negedge clk);
      strobe();
      check_all($sformatf("R2/R3/R4/R5 vec%0d", i), int'(VEC[i][3:0]));
    end

    // R7 exact step cycle, index 2 -> 1
    udr_raw = 1'b1; ovr_raw = 1'b0;
    repeat (8) @(negedge clk);
    az_strobe = 1'b1;
    @(negedge clk); check("R7 edge0", int'(range_idx), 2);
    @(negedge clk); check("R7 edge1", int'(range_idx), 2);
    @(negedge clk); check("R7 edge2", int'(range_idx), 1);
    // R6 strobe held high: no more steps
    repeat (20) @(negedge clk);
    check("R6 held strobe", int'(range_idx), 1);
    az_strobe = 1'b0;
    repeat (10) @(negedge clk);
    check("R6 no edge", int'(range_idx), 1);
    udr_raw = 1'b0;
    repeat (8) @(negedge clk);

    // R8 short pulse ignored
    ovr_raw = 1'b1;
    repeat (3) @(negedge clk);
    ovr_raw = 1'b0;
    repeat (2) @(negedge clk);
    strobe();
    check("R8 3-cycle pulse", int'(range_idx), 1);

    // R8 4-cycle pulse accepted, still counted at the step
    ovr_raw = 1'b1;
    repeat (4) @(negedge clk);
    ovr_raw = 1'b0;
    strobe();
    check("R8 4-cycle pulse", int'(range_idx), 2);
    repeat (8) @(negedge clk);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid reset", 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule